// File: doc/BRIEF.md
# Embedded Sync Code Decoder

This block sits on a parallel camera byte bus and recovers frame and line timing from marker codes carried inside the pixel stream, so no dedicated sync wires are needed. A marker is an escape prefix of three bytes, 0xFF then 0x00 then 0x00, followed by one code byte. The code byte is matched against four programmable values: open frame, open line, close line and close frame. The decoder checks that the markers arrive in a legal order. It drives frame-valid, line-valid and data-valid levels, one-cycle pulses at each boundary, and a sticky sync-error flag that is cleared by writing one.

When embedded mode is off, the decoder sits idle and the timing follows two level inputs instead: a frame-active pin and a line-active pin. Each byte is qualified by a pixel-rate strobe that is synchronous to the block clock.

There are two state machines. The prefix hunter has four states. HUNT goes to ESC1 on 0xFF and forwards any other byte as data. ESC1 goes to ESC2 on 0x00, and ESC2 goes to ESC3 on 0x00. On any other byte, ESC1 and ESC2 return to HUNT with a broken-prefix error. ESC3 always returns to HUNT and classifies the code byte. The frame tracker has three states. OUTSIDE goes to BETWEEN on open-frame. BETWEEN goes to INLINE on open-line, and back to OUTSIDE on close-frame. INLINE goes to BETWEEN on close-line. Every other code, and every unknown code, leaves the tracker state unchanged and raises the error.

Top module: `embsync_decoder`

## Requirements
- R1: After reset every output is 0: frame_valid, line_valid, data_valid, data_out, the four pulses and sync_err.
- R2: In embedded mode, a strobed sequence 0xFF, 0x00, 0x00, code_open_frame taken outside a frame sets frame_valid. On the clock edge that samples the code byte, frame_start pulses for exactly one cycle.
- R3: Inside a frame but outside a line, an open-line marker sets line_valid and pulses line_start. Inside a line, a close-line marker clears line_valid, keeps frame_valid and pulses line_end.
- R4: Between lines, a close-frame marker clears frame_valid and pulses frame_end.
- R5: A strobed byte that is not part of a marker appears on data_out with data_valid high one cycle after its strobe, but only inside a line. Prefix bytes, code bytes and bytes outside a line are never forwarded. 0x00 is legal pixel data, and 0xFF always begins a prefix.
- R6: An open-line marker while a line is open sets sync_err and the line stays open. A close-frame marker inside a line also sets sync_err and leaves both frame_valid and line_valid set.
- R7: A code byte that matches none of the four programmed values sets sync_err and leaves the timing unchanged. The very next prefix is decoded normally.
- R8: A broken prefix sets sync_err and drops the bytes taken so far. A broken prefix is 0xFF followed by a byte other than 0x00, or 0xFF 0x00 followed by a byte other than 0x00. Hunting then restarts at the next byte.
- R9: sync_err stays set until a cycle with err_clear high. If a new error and err_clear occur in the same cycle, the error wins.
- R10: Each of the following sets sync_err and leaves the timing unchanged: an open-line, close-line or close-frame marker outside a frame; a close-line marker between lines; an open-frame marker inside a frame.
- R11: With embedded_mode low, the state is sampled at each strobe. frame_valid follows hw_frame, and line_valid follows hw_frame AND hw_line. The pulses mark the rising and falling edges of these two levels, and data_valid accompanies every strobe inside a line. Marker bytes are plain data in this mode and never set sync_err.
- R12: When programmed codes are equal, the match priority is open-frame, then open-line, then close-line, then close-frame.
- R13: Bytes presented while pix_stb is low have no effect in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| embedded_mode | input | 1 | 1: decode in-band markers; 0: follow hw_frame/hw_line |
| pix_stb | input | 1 | Qualifies pix_byte for one clock |
| pix_byte | input | DATA_W | Incoming camera byte |
| hw_frame | input | 1 | Frame-active level used when embedded_mode is 0 |
| hw_line | input | 1 | Line-active level used when embedded_mode is 0 |
| code_open_frame | input | DATA_W | Programmed frame-start code |
| code_open_line | input | DATA_W | Programmed line-start code |
| code_close_line | input | DATA_W | Programmed line-end code |
| code_close_frame | input | DATA_W | Programmed frame-end code |
| err_clear | input | 1 | Write-one clear of sync_err |
| frame_valid | output | 1 | Inside a frame |
| line_valid | output | 1 | Inside a line |
| data_valid | output | 1 | data_out holds a forwarded pixel byte |
| data_out | output | DATA_W | Forwarded pixel byte |
| frame_start | output | 1 | One-cycle pulse at frame open |
| line_start | output | 1 | One-cycle pulse at line open |
| line_end | output | 1 | One-cycle pulse at line close |
| frame_end | output | 1 | One-cycle pulse at frame close |
| sync_err | output | 1 | Sticky synchronisation error |

## Verification
The main decode path is driven with a vector table holding a complete two-line frame. Pixel bytes appear outside lines, between lines and inside lines, and 0x00 occurs as pixel data. This separates forwarding that depends on line state from forwarding that depends only on the prefix. Directed sequences then feed every out-of-order marker, unknown codes, and prefixes broken after one and after two bytes. They show that the error fires while the timing levels hold and that hunting resumes cleanly. Further cases program equal codes to expose the match priority, hold bytes without a strobe, and switch to pin mode, where marker bytes must pass as data with no error.

// File: rtl/esc_pkg.sv
package esc_pkg;

    // prefix hunter states
    typedef enum logic [1:0] {
        HUNT = 2'd0,
        ESC1 = 2'd1,
        ESC2 = 2'd2,
        ESC3 = 2'd3
    } hunt_state_t;

    // frame tracker states
    typedef enum logic [1:0] {
        OUTSIDE = 2'd0,
        BETWEEN = 2'd1,
        INLINE  = 2'd2
    } track_state_t;

    // one classified event per strobed byte
    typedef enum logic [2:0] {
        EV_NONE    = 3'd0,
        EV_DATA    = 3'd1,
        EV_FS      = 3'd2,
        EV_LS      = 3'd3,
        EV_LE      = 3'd4,
        EV_FE      = 3'd5,
        EV_BADCODE = 3'd6,
        EV_BADPFX  = 3'd7
    } event_t;

    typedef struct packed {
        logic frame_on;
        logic line_on;
        logic data_on;
        logic sof;
        logic sol;
        logic eol;
        logic eof;
    } timing_t;

endpackage

// File: rtl/esc_prefix_hunter.sv
module esc_prefix_hunter
    import esc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              stb,
    input  logic [DATA_W-1:0] byte_in,
    input  logic [DATA_W-1:0] c_fs,
    input  logic [DATA_W-1:0] c_ls,
    input  logic [DATA_W-1:0] c_le,
    input  logic [DATA_W-1:0] c_fe,
    output event_t            ev
);

    localparam logic [DATA_W-1:0] ESC_HI = {DATA_W{1'b1}};
    localparam logic [DATA_W-1:0] ESC_LO = {DATA_W{1'b0}};

    hunt_state_t st, nxt;
    logic        take;

    assign take = stb & enable;

    // fixed match priority: open frame, open line, close line, close frame
    function automatic event_t classify(input logic [DATA_W-1:0] b,
                                        input logic [DATA_W-1:0] fs,
                                        input logic [DATA_W-1:0] ls,
                                        input logic [DATA_W-1:0] le,
                                        input logic [DATA_W-1:0] fe);
        if (b == fs)      return EV_FS;
        else if (b == ls) return EV_LS;
        else if (b == le) return EV_LE;
        else if (b == fe) return EV_FE;
        else              return EV_BADCODE;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       st <= HUNT;
        else if (!enable) st <= HUNT;
        else              st <= nxt;
    end

    always_comb begin
        nxt = st;
        ev  = EV_NONE;
        if (take) begin
            unique case (st)
                HUNT: begin
                    if (byte_in == ESC_HI) nxt = ESC1;
                    else                   ev  = EV_DATA;
                end
                ESC1: begin
                    if (byte_in == ESC_LO) nxt = ESC2;
                    else begin
                        nxt = HUNT;
                        ev  = EV_BADPFX;
                    end
                end
                ESC2: begin
                    if (byte_in == ESC_LO) nxt = ESC3;
                    else begin
                        nxt = HUNT;
                        ev  = EV_BADPFX;
                    end
                end
                ESC3: begin
                    nxt = HUNT;
                    ev  = classify(byte_in, c_fs, c_ls, c_le, c_fe);
                end
            endcase
        end
    end

    // R7 / R8: after a code byte or a broken prefix the hunter is back at HUNT
    a_r7_back_to_hunt: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (st == ESC3)) |=> (st == HUNT));
    a_r8_broken_prefix_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (st == ESC1) && (byte_in != ESC_LO)) |=> (st == HUNT));

endmodule

// File: rtl/esc_frame_tracker.sv
module esc_frame_tracker
    import esc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  event_t            ev,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              err_clear,
    output timing_t           tim,
    output logic [DATA_W-1:0] data_q,
    output logic              err_q
);

    track_state_t st, nxt;
    logic go_sof, go_sol, go_eol, go_eof, fwd, viol;
    logic sof_q, sol_q, eol_q, eof_q, dv_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       st <= OUTSIDE;
        else if (!enable) st <= OUTSIDE;
        else              st <= nxt;
    end

    // transitions
    always_comb begin
        nxt    = st;
        go_sof = 1'b0;
        go_sol = 1'b0;
        go_eol = 1'b0;
        go_eof = 1'b0;
        fwd    = 1'b0;
        viol   = 1'b0;
        unique case (ev)
            EV_NONE: ;
            EV_DATA: fwd = (st == INLINE);
            EV_FS: begin
                if (st == OUTSIDE) begin nxt = BETWEEN; go_sof = 1'b1; end
                else viol = 1'b1;
            end
            EV_LS: begin
                if (st == BETWEEN) begin nxt = INLINE; go_sol = 1'b1; end
                else viol = 1'b1;
            end
            EV_LE: begin
                if (st == INLINE) begin nxt = BETWEEN; go_eol = 1'b1; end
                else viol = 1'b1;
            end
            EV_FE: begin
                if (st == BETWEEN) begin nxt = OUTSIDE; go_eof = 1'b1; end
                else viol = 1'b1;
            end
            EV_BADCODE, EV_BADPFX: viol = 1'b1;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sof_q  <= 1'b0;
            sol_q  <= 1'b0;
            eol_q  <= 1'b0;
            eof_q  <= 1'b0;
            dv_q   <= 1'b0;
            data_q <= '0;
            err_q  <= 1'b0;
        end else begin
            sof_q <= enable & go_sof;
            sol_q <= enable & go_sol;
            eol_q <= enable & go_eol;
            eof_q <= enable & go_eof;
            dv_q  <= enable & fwd;
            if (enable && fwd) data_q <= byte_in;
            if (enable && viol)  err_q <= 1'b1;
            else if (err_clear)  err_q <= 1'b0;
        end
    end

    assign tim.frame_on = (st != OUTSIDE);
    assign tim.line_on  = (st == INLINE);
    assign tim.data_on  = dv_q;
    assign tim.sof      = sof_q;
    assign tim.sol      = sol_q;
    assign tim.eol      = eol_q;
    assign tim.eof      = eof_q;

    a_r3_line_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
        tim.line_on |-> tim.frame_on);
    a_r2_sof_opens_frame: assert property (@(posedge clk) disable iff (!rst_n)
        tim.sof |-> (tim.frame_on && !tim.line_on));
    a_r3_eol_keeps_frame: assert property (@(posedge clk) disable iff (!rst_n)
        tim.eol |-> (tim.frame_on && !tim.line_on));
    a_r4_eof_closes_frame: assert property (@(posedge clk) disable iff (!rst_n)
        tim.eof |-> !tim.frame_on);
    a_r5_data_only_in_line: assert property (@(posedge clk) disable iff (!rst_n)
        tim.data_on |-> tim.line_on);
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !err_clear) |=> err_q);
    a_r6_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tim.sof, tim.sol, tim.eol, tim.eof}));

endmodule

// File: rtl/esc_pin_sync.sv
module esc_pin_sync
    import esc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              stb,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              frame_lvl,
    input  logic              line_lvl,
    output timing_t           tim,
    output logic [DATA_W-1:0] data_q
);

    logic f_q, l_q, sof_q, sol_q, eol_q, eof_q, dv_q;
    logic take, l_new;

    assign take  = stb & enable;
    assign l_new = frame_lvl & line_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= 1'b0; l_q <= 1'b0;
            sof_q <= 1'b0; sol_q <= 1'b0; eol_q <= 1'b0; eof_q <= 1'b0;
            dv_q <= 1'b0; data_q <= '0;
        end else if (!enable) begin
            f_q <= 1'b0; l_q <= 1'b0;
            sof_q <= 1'b0; sol_q <= 1'b0; eol_q <= 1'b0; eof_q <= 1'b0;
            dv_q <= 1'b0;
        end else begin
            sof_q <= take &  frame_lvl & ~f_q;
            eof_q <= take & ~frame_lvl &  f_q;
            sol_q <= take &  l_new & ~l_q;
            eol_q <= take & ~l_new &  l_q;
            dv_q  <= take &  l_new;
            if (take) begin
                f_q <= frame_lvl;
                l_q <= l_new;
                if (l_new) data_q <= byte_in;
            end
        end
    end

    assign tim.frame_on = f_q;
    assign tim.line_on  = l_q;
    assign tim.data_on  = dv_q;
    assign tim.sof      = sof_q;
    assign tim.sol      = sol_q;
    assign tim.eol      = eol_q;
    assign tim.eof      = eof_q;

    a_r11_pin_line_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        l_q |-> f_q);
    a_r11_pin_sof_edge: assert property (@(posedge clk) disable iff (!rst_n)
        sof_q |-> (f_q && !$past(f_q)));

endmodule

// File: rtl/embsync_decoder.sv
module embsync_decoder
    import esc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              embedded_mode,
    input  logic              pix_stb,
    input  logic [DATA_W-1:0] pix_byte,
    input  logic              hw_frame,
    input  logic              hw_line,
    input  logic [DATA_W-1:0] code_open_frame,
    input  logic [DATA_W-1:0] code_open_line,
    input  logic [DATA_W-1:0] code_close_line,
    input  logic [DATA_W-1:0] code_close_frame,
    input  logic              err_clear,
    output logic              frame_valid,
    output logic              line_valid,
    output logic              data_valid,
    output logic [DATA_W-1:0] data_out,
    output logic              frame_start,
    output logic              line_start,
    output logic              line_end,
    output logic              frame_end,
    output logic              sync_err
);

    event_t            ev;
    timing_t           tim_emb, tim_pin, tim_sel;
    logic [DATA_W-1:0] data_emb, data_pin;

    esc_prefix_hunter #(.DATA_W(DATA_W)) u_hunter (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (embedded_mode),
        .stb     (pix_stb),
        .byte_in (pix_byte),
        .c_fs    (code_open_frame),
        .c_ls    (code_open_line),
        .c_le    (code_close_line),
        .c_fe    (code_close_frame),
        .ev      (ev)
    );

    esc_frame_tracker #(.DATA_W(DATA_W)) u_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (embedded_mode),
        .ev        (ev),
        .byte_in   (pix_byte),
        .err_clear (err_clear),
        .tim       (tim_emb),
        .data_q    (data_emb),
        .err_q     (sync_err)
    );

    esc_pin_sync #(.DATA_W(DATA_W)) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (!embedded_mode),
        .stb       (pix_stb),
        .byte_in   (pix_byte),
        .frame_lvl (hw_frame),
        .line_lvl  (hw_line),
        .tim       (tim_pin),
        .data_q    (data_pin)
    );

    assign tim_sel     = embedded_mode ? tim_emb  : tim_pin;
    assign data_out    = embedded_mode ? data_emb : data_pin;
    assign frame_valid = tim_sel.frame_on;
    assign line_valid  = tim_sel.line_on;
    assign data_valid  = tim_sel.data_on;
    assign frame_start = tim_sel.sof;
    assign line_start  = tim_sel.sol;
    assign line_end    = tim_sel.eol;
    assign frame_end   = tim_sel.eof;

    a_r13_no_strobe_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_stb && $stable(embedded_mode)) |=>
            !(data_valid || frame_start || line_start || line_end || frame_end));
    a_r11_pin_mode_no_error: assert property (@(posedge clk) disable iff (!rst_n)
        (!embedded_mode && !sync_err) |=> !sync_err);

endmodule

// File: tb/test_embsync_decoder.sv
`timescale 1ns/1ps
module test_embsync_decoder;

    localparam logic [7:0] FS = 8'hAB, LS = 8'h80, LE = 8'h9D, FE = 8'hB6;

    // {byte, fv, lv, dv, err, sof, sol, eol, eof}
    localparam int NV = 31;
    localparam logic [15:0] VEC [NV] = '{
        16'h1200, 16'hFF00, 16'h0000, 16'h0000, 16'hAB88,
        16'h3380, 16'hFF80, 16'h0080, 16'h0080, 16'h80C4,
        16'h11E0, 16'h00E0, 16'h22E0, 16'hFFC0, 16'h00C0,
        16'h00C0, 16'h9D82, 16'hFF80, 16'h0080, 16'h0080,
        16'h80C4, 16'h44E0, 16'hFFC0, 16'h00C0, 16'h00C0,
        16'h9D82, 16'hFF80, 16'h0080, 16'h0080, 16'hB601,
        16'h5500
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic embedded_mode = 1'b1, pix_stb = 1'b0, hw_frame = 1'b0, hw_line = 1'b0;
    logic err_clear = 1'b0;
    logic [7:0] pix_byte = 8'h00;
    logic [7:0] c_fs = FS, c_ls = LS, c_le = LE, c_fe = FE;
    logic frame_valid, line_valid, data_valid, frame_start, line_start, line_end, frame_end, sync_err;
    logic [7:0] data_out;
    int checks = 0, fails = 0;

    always #5 clk = ~clk;

    embsync_decoder #(.DATA_W(8)) i_embsync_decoder (
        .clk(clk), .rst_n(rst_n), .embedded_mode(embedded_mode),
        .pix_stb(pix_stb), .pix_byte(pix_byte), .hw_frame(hw_frame), .hw_line(hw_line),
        .code_open_frame(c_fs), .code_open_line(c_ls),
        .code_close_line(c_le), .code_close_frame(c_fe), .err_clear(err_clear),
        .frame_valid(frame_valid), .line_valid(line_valid), .data_valid(data_valid),
        .data_out(data_out), .frame_start(frame_start), .line_start(line_start),
        .line_end(line_end), .frame_end(frame_end), .sync_err(sync_err)
    );

    function automatic logic [7:0] flags();
        return {frame_valid, line_valid, data_valid, sync_err,
                frame_start, line_start, line_end, frame_end};
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        pix_stb  = 1'b1;
        pix_byte = b;
        @(negedge clk);
        pix_stb  = 1'b0;
    endtask

    task automatic code(input logic [7:0] c);
        put(8'hFF); put(8'h00); put(8'h00); put(c);
    endtask

    task automatic clr();
        err_clear = 1'b1;
        @(negedge clk);
        err_clear = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset flags", {8'h0, flags()}, 16'h0000);
        chk("R1 reset data", {8'h0, data_out}, 16'h0000);

        // table walk: R2 R3 R4 R5
        for (int i = 0; i < NV; i++) begin
            put(VEC[i][15:8]);
            chk($sformatf("R2/R3/R4/R5 vector %0d", i), {8'h0, flags()}, {8'h0, VEC[i][7:0]});
            if (VEC[i][5])
                chk($sformatf("R5 data vector %0d", i), {8'h0, data_out}, {8'h0, VEC[i][15:8]});
        end

        // R13: bytes without strobe
        code(FS);
        chk("R2 open frame", {8'h0, flags()}, 16'h0088);
        pix_byte = 8'hFF; @(negedge clk);
        pix_byte = 8'h00; @(negedge clk);
        @(negedge clk);
        pix_byte = LS;    @(negedge clk);
        chk("R13 unstrobed marker ignored", {8'h0, flags()}, 16'h0080);

        // R6: open-line inside line
        code(LS);
        chk("R3 open line", {8'h0, flags()}, 16'h00C4);
        code(LS);
        chk("R6 open line in line", {8'h0, flags()}, 16'h00D0);
        repeat (3) @(negedge clk);
        chk("R9 error sticky", {8'h0, flags()}, 16'h00D0);
        clr();
        chk("R9 cleared", {8'h0, flags()}, 16'h00C0);
        err_clear = 1'b1;
        code(FE);
        err_clear = 1'b0;
        chk("R6 close frame in line, R9 set wins", {8'h0, flags()}, 16'h00D0);
        clr();

        // R7: unknown code then recovery
        code(8'h5C);
        chk("R7 unknown code", {8'h0, flags()}, 16'h00D0);
        clr();
        code(LE);
        chk("R7 resumes after unknown", {8'h0, flags()}, 16'h0082);

        // R8: broken prefixes
        put(8'hFF); put(8'h12);
        chk("R8 broken after one", {8'h0, flags()}, 16'h0090);
        clr();
        put(8'hFF); put(8'h00); put(8'h34);
        chk("R8 broken after two", {8'h0, flags()}, 16'h0090);
        clr();
        code(LS);
        put(8'h66);
        chk("R8 hunt restarted", {8'h0, flags()}, 16'h00E0);
        chk("R5 data after restart", {8'h0, data_out}, 16'h0066);
        code(LE);

        // R10: illegal orders
        code(LE);
        chk("R10 close line between lines", {8'h0, flags()}, 16'h0090);
        clr();
        code(FS);
        chk("R10 open frame inside frame", {8'h0, flags()}, 16'h0090);
        clr();
        code(FE);
        chk("R4 close frame", {8'h0, flags()}, 16'h0001);
        code(LS);
        chk("R10 open line outside frame", {8'h0, flags()}, 16'h0010);
        clr();
        code(FE);
        chk("R10 close frame outside frame", {8'h0, flags()}, 16'h0010);
        clr();

        // R12: priority with equal codes
        c_ls = FS;
        code(FS);
        chk("R12 open frame beats open line", {8'h0, flags()}, 16'h0088);
        c_ls = LS;
        code(LS);
        c_fe = LE;
        code(LE);
        chk("R12 close line beats close frame", {8'h0, flags()}, 16'h0082);
        c_fe = FE;
        code(FE);
        chk("R4 close frame after priority", {8'h0, flags()}, 16'h0001);

        // R11: pin mode
        embedded_mode = 1'b0;
        put(8'h10);
        chk("R11 pin idle", {8'h0, flags()}, 16'h0000);
        hw_frame = 1'b1;
        put(8'h20);
        chk("R11 pin frame open", {8'h0, flags()}, 16'h0088);
        hw_line = 1'b1;
        put(8'hFF);
        chk("R11 pin line open", {8'h0, flags()}, 16'h00E4);
        chk("R11 pin data", {8'h0, data_out}, 16'h00FF);
        put(8'h00); put(8'h00); put(8'h5C);
        chk("R11 marker bytes are data", {8'h0, flags()}, 16'h00E0);
        hw_line = 1'b0;
        put(8'h30);
        chk("R11 pin line close", {8'h0, flags()}, 16'h0082);
        hw_frame = 1'b0;
        put(8'h40);
        chk("R11 pin frame close", {8'h0, flags()}, 16'h0001);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule